// File: doc/BRIEF.md
# Johnson decade counter with segment decoder

This block is one digit of a decimal counter. It keeps its count in a five-stage twisted-ring (Johnson) register. The register steps through ten codes for the counts 0 to 9. The code is decoded directly into active-high seven-segment drive, with no binary form in between.

A clock inhibit freezes the count. An asynchronous active-high reset returns the count to zero. The display enable blanks the seven gated segments and is also passed on so that the next digit of a chain can be enabled. Any code that falls outside the ten legal ones is repaired on the next enabled clock.

Two outputs serve the surrounding design. A square-wave carry clocks the next decade directly. An ungated copy of segment c is unaffected by display enable, so logic outside the block can recognise the digit 2.

Top module: `johnson_decade_seg`

## Requirements
- R1: Each rising clock edge with inhibit low advances the count by one, from 9 back to 0. Seven-segment patterns are packed {a,b,c,d,e,f,g} with a in bit 6, and for digits 0 to 9 they are hex 7E, 30, 6D, 79, 33, 5B, 5F, 70, 7F, 7B. This means 6 includes a and 9 includes d.
- R2: A high reset forces count 0 at once, without waiting for a clock edge. Reset takes precedence over clock inhibit and over clock edges for as long as it is high.
- R3: While clock inhibit is high at a rising edge, the count and every output that depends on it hold their values.
- R4: The state register is five bits. The legal code for count n is as follows: for n from 0 to 5, the low n bits are set; for n from 6 to 9, all bits are set except the low n-5. If the register holds any of the other 22 codes, the next clock edge with inhibit low loads count 0.
- R5: The carry output is high for counts 0 to 4 and low for counts 5 to 9. It therefore rises exactly once per ten advancing clocks, at the wrap from 9 to 0.
- R6: The ungated c output is low only at count 2 and high at every other count, whatever the display enable is.
- R7: While display enable is high, the segment output shows the pattern of the current count. While it is low, all seven segments are low.
- R8: The display-enable output follows the display-enable input combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting clock, rising edge |
| rst | input | 1 | Asynchronous reset to count 0, active high |
| clkInhibit | input | 1 | Holds the count when high |
| dispEnIn | input | 1 | Enables the gated segments |
| segOut | output | 7 | Gated segments {a,b,c,d,e,f,g}, active high |
| dispEnOut | output | 1 | Copy of dispEnIn for the next digit |
| carryOut | output | 1 | Decade carry, high for counts 0 to 4 |
| ucsOut | output | 1 | Ungated segment c |

## Verification
Two pairs of functions can fall in the same cycle.

The first pair is reset and clock inhibit. The bench raises reset in the middle of a cycle while inhibit is high. It checks for count 0 before any edge arrives, and again after an edge that occurs with both inputs high.

The second pair is illegal-state repair and the release of inhibit. Each of the 22 illegal codes is forced into the register while inhibit is high. Inhibit is then dropped, and the first enabled edge must both repair the code and resume counting from zero. A behavioural model then follows the digit edge by edge.

// File: rtl/jds_pkg.sv
package jds_pkg;

  typedef struct packed {
    logic advance;
    logic repair;
  } jdsStrobe_t;

  function automatic logic [6:0] segPattern(input int digit);
    logic [6:0] pat;
    case (digit)
      0:       pat = 7'b1111110;
      1:       pat = 7'b0110000;
      2:       pat = 7'b1101101;
      3:       pat = 7'b1111001;
      4:       pat = 7'b0110011;
      5:       pat = 7'b1011011;
      6:       pat = 7'b1011111;
      7:       pat = 7'b1110000;
      8:       pat = 7'b1111111;
      9:       pat = 7'b1111011;
      default: pat = 7'b0000000;
    endcase
    return pat;
  endfunction

endpackage

// File: rtl/jds_control.sv
module jds_control
  import jds_pkg::*;
#(
  parameter int STAGES = 5
) (
  input  logic              clkInhibit,
  input  logic [STAGES-1:0] stateQ,
  output jdsStrobe_t        strobes
);

  localparam int EDGES = STAGES - 1;

  logic [EDGES-1:0] bitDiff;
  int               diffCount;
  logic             codeLegal;

  genvar gi;
  generate
    for (gi = 0; gi < EDGES; gi++) begin : g_diff
      assign bitDiff[gi] = stateQ[gi] ^ stateQ[gi+1];
    end
  endgenerate

  always_comb begin
    diffCount = 0;
    for (int i = 0; i < EDGES; i++) begin
      if (bitDiff[i]) diffCount = diffCount + 1;
    end
    codeLegal = (diffCount <= 1);
  end

  always_comb begin
    strobes.advance = ~clkInhibit;
    strobes.repair  = ~clkInhibit & ~codeLegal;
  end

endmodule

// File: rtl/jds_datapath.sv
module jds_datapath
  import jds_pkg::*;
#(
  parameter int STAGES = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  jdsStrobe_t        strobes,
  output logic [STAGES-1:0] stateQ
);

  logic [STAGES-1:0] stateNext;

  always_comb begin
    stateNext = stateQ;
    if (strobes.repair) begin
      stateNext = '0;
    end else if (strobes.advance) begin
      stateNext = {stateQ[STAGES-2:0], ~stateQ[STAGES-1]};
    end
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      stateQ <= '0;
    end else begin
      stateQ <= stateNext;
    end
  end

endmodule

// File: rtl/jds_decoder.sv
module jds_decoder
  import jds_pkg::*;
#(
  parameter int STAGES = 5
) (
  input  logic [STAGES-1:0] stateQ,
  output logic [6:0]        segRaw,
  output logic              ucsRaw,
  output logic              carryRaw
);

  localparam int COUNTS = 2 * STAGES;

  logic [COUNTS-1:0] digitHot;

  genvar gk;
  generate
    for (gk = 0; gk < COUNTS; gk++) begin : g_digit
      if (gk == 0) begin : g_zero
        assign digitHot[gk] = ~stateQ[STAGES-1] & ~stateQ[0];
      end else if (gk < STAGES) begin : g_fill
        assign digitHot[gk] = stateQ[gk-1] & ~stateQ[gk];
      end else if (gk == STAGES) begin : g_full
        assign digitHot[gk] = stateQ[STAGES-1] & stateQ[0];
      end else begin : g_drain
        assign digitHot[gk] = ~stateQ[gk-STAGES-1] & stateQ[gk-STAGES];
      end
    end
  endgenerate

  always_comb begin
    segRaw = '0;
    for (int k = 0; k < COUNTS; k++) begin
      if (digitHot[k]) segRaw = segRaw | segPattern(k % 10);
    end
  end

  assign ucsRaw   = ~digitHot[2];
  assign carryRaw = ~stateQ[STAGES-1];

endmodule

// File: rtl/johnson_decade_seg.sv
module johnson_decade_seg
  import jds_pkg::*;
#(
  parameter int STAGES = 5
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       clkInhibit,
  input  logic       dispEnIn,
  output logic [6:0] segOut,
  output logic       dispEnOut,
  output logic       carryOut,
  output logic       ucsOut
);

  jdsStrobe_t        strobes;
  logic [STAGES-1:0] stateQ;
  logic [6:0]        segRaw;
  logic              ucsRaw;
  logic              carryRaw;

  jds_control #(.STAGES(STAGES)) u_control (
    .clkInhibit (clkInhibit),
    .stateQ     (stateQ),
    .strobes    (strobes)
  );

  jds_datapath #(.STAGES(STAGES)) u_datapath (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes),
    .stateQ  (stateQ)
  );

  jds_decoder #(.STAGES(STAGES)) u_decoder (
    .stateQ   (stateQ),
    .segRaw   (segRaw),
    .ucsRaw   (ucsRaw),
    .carryRaw (carryRaw)
  );

  assign segOut    = dispEnIn ? segRaw : 7'b0000000;
  assign dispEnOut = dispEnIn;
  assign carryOut  = carryRaw;
  assign ucsOut    = ucsRaw;

endmodule

// File: rtl/johnson_decade_seg_checker.sv
module johnson_decade_seg_checker #(
  parameter int STAGES = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              clkInhibit,
  input logic              dispEnIn,
  input logic [6:0]        segOut,
  input logic              dispEnOut,
  input logic              carryOut,
  input logic              ucsOut,
  input logic [STAGES-1:0] stateQ
);

  localparam int COUNTS = 2 * STAGES;

  logic inCycle;

  always_comb begin
    inCycle = 1'b0;
    for (int n = 0; n < COUNTS; n++) begin
      if (n <= STAGES) begin
        if (stateQ == STAGES'((1 << n) - 1)) inCycle = 1'b1;
      end else begin
        if (stateQ == STAGES'(((1 << STAGES) - 1) & ~((1 << (n - STAGES)) - 1))) inCycle = 1'b1;
      end
    end
  end

  p_reset_zero_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (carryOut && ucsOut && stateQ == '0));

  p_inhibit_hold_r3: assert property (@(posedge clk) disable iff (rst)
    clkInhibit |=> ($stable(stateQ) && $stable(carryOut) && $stable(ucsOut)));

  p_repair_r4: assert property (@(posedge clk) disable iff (rst)
    (!clkInhibit && !inCycle) |=> (stateQ == '0));

  p_carry_rise_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(carryOut) |-> $past(!clkInhibit));

  p_blank_r7: assert property (@(posedge clk) disable iff (rst)
    !dispEnIn |-> (segOut == 7'b0000000));

  p_enable_copy_r8: assert property (@(posedge clk) disable iff (rst)
    dispEnOut == dispEnIn);

endmodule

bind johnson_decade_seg johnson_decade_seg_checker #(.STAGES(STAGES)) u_checker (
  .clk        (clk),
  .rst        (rst),
  .clkInhibit (clkInhibit),
  .dispEnIn   (dispEnIn),
  .segOut     (segOut),
  .dispEnOut  (dispEnOut),
  .carryOut   (carryOut),
  .ucsOut     (ucsOut),
  .stateQ     (stateQ)
);

// File: tb/test_johnson_decade_seg.sv
module test_johnson_decade_seg;

  logic       clk = 1'b0;
  logic       rst;
  logic       clkInhibit;
  logic       dispEnIn;
  logic [6:0] segOut;
  logic       dispEnOut;
  logic       carryOut;
  logic       ucsOut;

  int vectors = 0;
  int miscompares = 0;
  int modelCount = 0;
  bit forcedBad = 1'b0;

  logic [6:0] digitShape [10];

  always #10 clk = ~clk;

  johnson_decade_seg i_johnson_decade_seg (
    .clk        (clk),
    .rst        (rst),
    .clkInhibit (clkInhibit),
    .dispEnIn   (dispEnIn),
    .segOut     (segOut),
    .dispEnOut  (dispEnOut),
    .carryOut   (carryOut),
    .ucsOut     (ucsOut)
  );

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  task automatic checkBit(input string tag, input string name, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%b expected=%b (count %0d)", tag, name, act, exp, modelCount);
    end
  endtask

  task automatic checkAll(input string tag);
    logic [6:0] expSeg;
    expSeg = dispEnIn ? digitShape[modelCount] : 7'b0000000;
    vectors++;
    if (segOut !== expSeg) begin
      miscompares++;
      $display("FAIL %s %s segOut actual=%h expected=%h (count %0d)", tag,
               dispEnIn ? "R1" : "R7", segOut, expSeg, modelCount);
    end
    checkBit({tag, " R6"}, "ucsOut", ucsOut, modelCount != 2);
    checkBit({tag, " R5"}, "carryOut", carryOut, modelCount < 5);
    checkBit({tag, " R8"}, "dispEnOut", dispEnOut, dispEnIn);
  endtask

  task automatic step(input string tag);
    @(posedge clk);
    if (rst) begin
      modelCount = 0;
      forcedBad  = 1'b0;
    end else if (!clkInhibit) begin
      if (forcedBad) modelCount = 0;
      else modelCount = (modelCount + 1) % 10;
      forcedBad = 1'b0;
    end
    @(negedge clk);
    if (!forcedBad) checkAll(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired");
    report();
    $finish;
  end

  initial begin
    int carryRises;
    int illegalSeen;
    logic prevCarry;
    logic [4:0] legalCodes [$];

    digitShape[0] = 7'h7E; digitShape[1] = 7'h30; digitShape[2] = 7'h6D;
    digitShape[3] = 7'h79; digitShape[4] = 7'h33; digitShape[5] = 7'h5B;
    digitShape[6] = 7'h5F; digitShape[7] = 7'h70; digitShape[8] = 7'h7F;
    digitShape[9] = 7'h7B;

    rst = 1'b1; clkInhibit = 1'b0; dispEnIn = 1'b1;
    @(negedge clk);
    @(negedge clk);
    checkAll("R2 reset state");
    rst = 1'b0;

    // R1 R5: count sweep with display on, counting carry rises
    carryRises = 0;
    prevCarry  = carryOut;
    for (int i = 0; i < 30; i++) begin
      step("R1 sweep");
      if (carryOut && !prevCarry) carryRises++;
      prevCarry = carryOut;
    end
    checkBit("R5 carry rises in 30", "rises", carryRises == 3, 1'b1);

    // R7 R6 R8: display blanked while counting
    dispEnIn = 1'b0;
    for (int i = 0; i < 12; i++) step("R7 blank");
    dispEnIn = 1'b1;

    // R3: inhibit held, display toggled
    clkInhibit = 1'b1;
    for (int i = 0; i < 6; i++) begin
      dispEnIn = i[0];
      step("R3 hold");
    end
    dispEnIn = 1'b1;
    for (int i = 0; i < 24; i++) begin
      clkInhibit = (i % 3 == 1);
      step("R3 mixed");
    end
    clkInhibit = 1'b0;

    // R2: asynchronous reset mid-cycle while inhibited
    for (int i = 0; i < 3; i++) step("R1 pre-reset");
    clkInhibit = 1'b1;
    #3;
    rst = 1'b1;
    modelCount = 0;
    #2;
    checkAll("R2 async");
    step("R2 reset over inhibit");
    rst = 1'b0;
    step("R2 after reset inhibited");
    clkInhibit = 1'b0;
    for (int i = 0; i < 12; i++) step("R1 after reset");

    // R4: every illegal code is repaired on the first enabled edge
    for (int n = 0; n < 10; n++) begin
      if (n <= 5) legalCodes.push_back(5'((1 << n) - 1));
      else legalCodes.push_back(5'(31 & ~((1 << (n - 5)) - 1)));
    end
    illegalSeen = 0;
    for (int v = 0; v < 32; v++) begin
      bit isLegal;
      isLegal = 1'b0;
      foreach (legalCodes[k]) if (legalCodes[k] == 5'(v)) isLegal = 1'b1;
      if (!isLegal) begin
        illegalSeen++;
        clkInhibit = 1'b1;
        force i_johnson_decade_seg.u_datapath.stateQ = 5'(v);
        #1;
        release i_johnson_decade_seg.u_datapath.stateQ;
        forcedBad = 1'b1;
        step("R4 inhibited illegal");
        clkInhibit = 1'b0;
        dispEnIn = v[0];
        step("R4 repaired");
        step("R4 resumed");
        dispEnIn = 1'b1;
      end
    end
    checkBit("R4 illegal code count", "is22", illegalSeen == 22, 1'b1);

    // R1 R5: wrap from 9 to 0 again after repair
    for (int i = 0; i < 12; i++) step("R5 wrap");

    report();
    $finish;
  end

endmodule